// File: doc/BRIEF.md
# Pixel Write Unit with Depth Test

This block sits at the end of a raster pipeline and handles one pixel per clock. Each pixel carries a source colour (operand A), the colour already in the frame buffer (operand B), a new depth and the depth already stored. A selectable raster operation combines A and B independently in every 8-bit colour channel. A per-bit plane mask then decides which result bits replace the destination. A depth comparison, together with one of four write policies, produces separate write enables for the frame buffer and the depth buffer.

The mode words live in three registers that a simple configuration port writes: the raster operation, the depth control and the plane mask. The result is registered, so every output appears one cycle after its pixel. A valid flag travels with the data. Both write enables are forced low in any cycle that carries no pixel.

Top module: `pixel_write_unit`

## Requirements
- R1: While reset is asserted and after its release, `out_valid`, `fb_we` and `zb_we` are 0. The reset configuration is: raster code 0x3E (pass A), plane mask all ones, compare select 00, compare enabled, policy 0.
- R2: A pixel presented with `pix_valid`=1 at a rising edge appears on the outputs right after that edge, with `out_valid`=1 and `out_depth` equal to its new depth. If there is no pixel, `out_valid` is 0 after that edge.
- R3: Raster codes 0x00–0x07 are additions in which bit 0 is the carry-in. Bit 1 inverts A and bit 2 inverts B. This gives 0x00 A+B, 0x01 A+B+1, 0x02 B−A−1, 0x03 B−A, 0x04 A−B−1, 0x05 A−B, 0x06 ~A+~B and 0x07 ~A+~B+1. Each channel wraps modulo 256, with no carry into the next channel and no saturation.
- R4: The logic codes are 0x28 A&B, 0x1E A|B, 0x22 A^B, 0x20 ~(A^B), 0x18 ~(A&B), 0x2E ~(A|B), 0x2A ~A&B, 0x2C A&~B, 0x1C ~A|B and 0x1A A|~B.
- R5: The constant and pass codes are 0x3E A, 0x3C ~A, 0x36 B, 0x32 ~B, 0x38 all zeros and 0x30 all ones.
- R6: Any raster code not listed in R3–R5 yields B, so the destination colour is left unchanged.
- R7: In each output colour bit, the raster result appears where the plane mask bit is 1, and the destination bit appears where it is 0.
- R8: The compare select (control bits 1:0) passes under these conditions, comparing depths as unsigned numbers: 00 new ≥ old, 01 new > old, 10 new < old, 11 new = old.
- R9: When control bit 2 is set, the depth test always passes.
- R10: The policy (control bits 4:3) sets the write enables. Policy 0 writes both buffers on pass. Policy 1 writes only the frame buffer, and only on pass. Policy 2 always writes both buffers. Policy 3 always writes the frame buffer and never the depth buffer. `zb_we`=1 therefore implies `fb_we`=1.
- R11: A configuration write with `cfg_we`=1 at an edge updates one register: address 0 takes the raster code from data bits 5:0, address 1 takes the control from bits 4:0, and address 2 takes the plane mask from bits 23:0. A write to address 3 changes nothing. A pixel presented at the same edge as a write still uses the old configuration.
- R12: An output cycle with `out_valid`=0 has `fb_we`=0 and `zb_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_data | input | 24 | Configuration write data |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_src | input | 24 | Source colour, operand A (three 8-bit channels) |
| pix_dst | input | 24 | Destination colour, operand B |
| pix_znew | input | 16 | Depth of the incoming pixel |
| pix_zold | input | 16 | Depth stored at the pixel location |
| out_valid | output | 1 | Output pixel present |
| out_color | output | 24 | Masked colour to write |
| out_depth | output | 16 | Depth to write |
| fb_we | output | 1 | Frame-buffer write enable |
| zb_we | output | 1 | Depth-buffer write enable |

## Verification
The assertions assume that every pixel and configuration input has a defined value at each sampled edge, and that reset is asserted once at start-up before any traffic. The mask property compares output bits against the destination of the previous cycle, so it relies on `pix_dst` being the colour that the pixel captured at that edge. The bench respects these assumptions by driving all inputs only on falling edges from its tasks. It gives every field a known value, including fields that an idle cycle ignores. It draws random data from a fixed seed over the full input ranges, including unlisted raster codes and equal or adjacent depths.

// File: rtl/pwu_pkg.sv
package pwu_pkg;

    // Raster operation codes; bit 0 of the additive family is the carry-in.
    typedef enum logic [5:0] {
        ROP_ADD      = 6'h00,
        ROP_ADD_C    = 6'h01,
        ROP_BSUBA_M1 = 6'h02,
        ROP_BSUBA    = 6'h03,
        ROP_ASUBB_M1 = 6'h04,
        ROP_ASUBB    = 6'h05,
        ROP_NSUM     = 6'h06,
        ROP_NSUM_C   = 6'h07,
        ROP_NAND     = 6'h18,
        ROP_A_OR_NB  = 6'h1A,
        ROP_NA_OR_B  = 6'h1C,
        ROP_OR       = 6'h1E,
        ROP_XNOR     = 6'h20,
        ROP_XOR      = 6'h22,
        ROP_AND      = 6'h28,
        ROP_NA_AND_B = 6'h2A,
        ROP_A_AND_NB = 6'h2C,
        ROP_NOR      = 6'h2E,
        ROP_ONES     = 6'h30,
        ROP_NOT_B    = 6'h32,
        ROP_PASS_B   = 6'h36,
        ROP_ZEROS    = 6'h38,
        ROP_NOT_A    = 6'h3C,
        ROP_PASS_A   = 6'h3E
    } rop_code_e;

    // Depth compare selector (note the non-monotonic code assignment).
    typedef enum logic [1:0] {
        ZCMP_GE = 2'b00,
        ZCMP_GT = 2'b01,
        ZCMP_LT = 2'b10,
        ZCMP_EQ = 2'b11
    } zcmp_sel_e;

    // Depth write policy.
    typedef enum logic [1:0] {
        ZPOL_TEST_BOTH  = 2'd0,
        ZPOL_TEST_FRAME = 2'd1,
        ZPOL_ALL_BOTH   = 2'd2,
        ZPOL_ALL_FRAME  = 2'd3
    } zpol_e;

    // Configuration register addresses.
    typedef enum logic [1:0] {
        CFG_ROP   = 2'd0,
        CFG_DEPTH = 2'd1,
        CFG_MASK  = 2'd2,
        CFG_SPARE = 2'd3
    } cfg_addr_e;

endpackage

// File: rtl/pwu_cfg_regs.sv
module pwu_cfg_regs
    import pwu_pkg::*;
#(
    parameter int CFG_W = 24,
    parameter int MASK_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic [5:0]        rop_q,
    output zcmp_sel_e         zsel_q,
    output logic              zoff_q,
    output zpol_e             zpol_q,
    output logic [MASK_W-1:0] mask_q
);

    localparam logic [5:0] ROP_RESET = ROP_PASS_A;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rop_q  <= ROP_RESET;
            zsel_q <= ZCMP_GE;
            zoff_q <= 1'b0;
            zpol_q <= ZPOL_TEST_BOTH;
            mask_q <= '1;
        end else if (cfg_we) begin
            unique case (cfg_addr_e'(cfg_addr))
                CFG_ROP: begin
                    rop_q <= cfg_data[5:0];
                end
                CFG_DEPTH: begin
                    zsel_q <= zcmp_sel_e'(cfg_data[1:0]);
                    zoff_q <= cfg_data[2];
                    zpol_q <= zpol_e'(cfg_data[4:3]);
                end
                CFG_MASK: begin
                    mask_q <= cfg_data[MASK_W-1:0];
                end
                CFG_SPARE: begin
                    rop_q <= rop_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwu_rop_lane.sv
module pwu_rop_lane
    import pwu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [5:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic [W-1:0] cin;
    logic         is_arith;

    always_comb begin
        is_arith = (op[5:3] == 3'b000);
        opa      = op[1] ? ~a : a;
        opb      = op[2] ? ~b : b;
        cin      = {{(W-1){1'b0}}, op[0]};
        y        = b;
        if (is_arith) begin
            y = opa + opb + cin;
        end else begin
            case (rop_code_e'(op))
                ROP_AND:      y = a & b;
                ROP_OR:       y = a | b;
                ROP_XOR:      y = a ^ b;
                ROP_XNOR:     y = ~(a ^ b);
                ROP_NAND:     y = ~(a & b);
                ROP_NOR:      y = ~(a | b);
                ROP_NA_AND_B: y = ~a & b;
                ROP_A_AND_NB: y = a & ~b;
                ROP_NA_OR_B:  y = ~a | b;
                ROP_A_OR_NB:  y = a | ~b;
                ROP_PASS_A:   y = a;
                ROP_NOT_A:    y = ~a;
                ROP_PASS_B:   y = b;
                ROP_NOT_B:    y = ~b;
                ROP_ZEROS:    y = '0;
                ROP_ONES:     y = '1;
                default:      y = b;
            endcase
        end
    end

endmodule

// File: rtl/pwu_depth_test.sv
module pwu_depth_test
    import pwu_pkg::*;
#(
    parameter int DEPTH_W = 16
) (
    input  logic [DEPTH_W-1:0] znew,
    input  logic [DEPTH_W-1:0] zold,
    input  zcmp_sel_e          zsel,
    input  logic               zoff,
    input  zpol_e              zpol,
    output logic               fb_en,
    output logic               zb_en
);

    logic cmp_ok;
    logic pass;

    always_comb begin
        unique case (zsel)
            ZCMP_GE: cmp_ok = (znew >= zold);
            ZCMP_GT: cmp_ok = (znew >  zold);
            ZCMP_LT: cmp_ok = (znew <  zold);
            ZCMP_EQ: cmp_ok = (znew == zold);
        endcase
        pass = zoff | cmp_ok;
    end

    always_comb begin
        unique case (zpol)
            ZPOL_TEST_BOTH:  begin fb_en = pass; zb_en = pass; end
            ZPOL_TEST_FRAME: begin fb_en = pass; zb_en = 1'b0; end
            ZPOL_ALL_BOTH:   begin fb_en = 1'b1; zb_en = 1'b1; end
            ZPOL_ALL_FRAME:  begin fb_en = 1'b1; zb_en = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pixel_write_unit.sv
module pixel_write_unit
    import pwu_pkg::*;
#(
    parameter int CH_W    = 8,
    parameter int NUM_CH  = 3,
    parameter int DEPTH_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_addr,
    input  logic [CH_W*NUM_CH-1:0]   cfg_data,
    input  logic                     pix_valid,
    input  logic [CH_W*NUM_CH-1:0]   pix_src,
    input  logic [CH_W*NUM_CH-1:0]   pix_dst,
    input  logic [DEPTH_W-1:0]       pix_znew,
    input  logic [DEPTH_W-1:0]       pix_zold,
    output logic                     out_valid,
    output logic [CH_W*NUM_CH-1:0]   out_color,
    output logic [DEPTH_W-1:0]       out_depth,
    output logic                     fb_we,
    output logic                     zb_we
);

    localparam int PIX_W = CH_W * NUM_CH;

    logic [5:0]       rop_q;
    zcmp_sel_e        zsel_q;
    logic             zoff_q;
    zpol_e            zpol_q;
    logic [PIX_W-1:0] mask_q;
    logic [PIX_W-1:0] rop_res;
    logic [PIX_W-1:0] color_d;
    logic             fb_en;
    logic             zb_en;

    pwu_cfg_regs #(
        .CFG_W  (PIX_W),
        .MASK_W (PIX_W)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .rop_q    (rop_q),
        .zsel_q   (zsel_q),
        .zoff_q   (zoff_q),
        .zpol_q   (zpol_q),
        .mask_q   (mask_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        pwu_rop_lane #(.W(CH_W)) lane_i (
            .op (rop_q),
            .a  (pix_src[ch*CH_W +: CH_W]),
            .b  (pix_dst[ch*CH_W +: CH_W]),
            .y  (rop_res[ch*CH_W +: CH_W])
        );
    end

    pwu_depth_test #(.DEPTH_W(DEPTH_W)) depth_i (
        .znew  (pix_znew),
        .zold  (pix_zold),
        .zsel  (zsel_q),
        .zoff  (zoff_q),
        .zpol  (zpol_q),
        .fb_en (fb_en),
        .zb_en (zb_en)
    );

    always_comb begin
        color_d = (rop_res & mask_q) | (pix_dst & ~mask_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_color <= '0;
            out_depth <= '0;
            fb_we     <= 1'b0;
            zb_we     <= 1'b0;
        end else begin
            out_valid <= pix_valid;
            out_color <= color_d;
            out_depth <= pix_znew;
            fb_we     <= pix_valid & fb_en;
            zb_we     <= pix_valid & zb_en;
        end
    end

endmodule

// File: rtl/pwu_checker.sv
module pwu_checker #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic [PIX_W-1:0] pix_dst,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_color,
    input logic             fb_we,
    input logic             zb_we,
    input logic [PIX_W-1:0] mask_q,
    input logic [1:0]       zpol_q,
    input logic             zoff_q
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    assert_no_write_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!fb_we && !zb_we));

    assert_depth_implies_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        zb_we |-> fb_we);

    assert_mask_keeps_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> ((out_color & ~$past(mask_q)) == ($past(pix_dst) & ~$past(mask_q))));

    assert_policy_always_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && zpol_q == 2'd2) |=> (fb_we && zb_we));

    assert_test_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && zoff_q && zpol_q == 2'd1) |=> (fb_we && !zb_we));

endmodule

bind pixel_write_unit pwu_checker #(.PIX_W(PIX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_dst   (pix_dst),
    .out_valid (out_valid),
    .out_color (out_color),
    .fb_we     (fb_we),
    .zb_we     (zb_we),
    .mask_q    (mask_q),
    .zpol_q    (zpol_q),
    .zoff_q    (zoff_q)
);

// File: tb/pixel_write_unit_tb_top.sv
`timescale 1ns/1ps
module pixel_write_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [23:0] cfg_data = '0;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_src = '0;
    logic [23:0] pix_dst = '0;
    logic [15:0] pix_znew = '0;
    logic [15:0] pix_zold = '0;
    logic        out_valid;
    logic [23:0] out_color;
    logic [15:0] out_depth;
    logic        fb_we;
    logic        zb_we;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model of the configuration.
    logic [5:0]  m_rop  = 6'h3E;
    logic [1:0]  m_sel  = 2'b00;
    logic        m_off  = 1'b0;
    logic [1:0]  m_pol  = 2'd0;
    logic [23:0] m_mask = 24'hFFFFFF;

    always #4 clk = ~clk;

    pixel_write_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .pix_valid(pix_valid), .pix_src(pix_src),
        .pix_dst(pix_dst), .pix_znew(pix_znew), .pix_zold(pix_zold),
        .out_valid(out_valid), .out_color(out_color), .out_depth(out_depth),
        .fb_we(fb_we), .zb_we(zb_we)
    );

    function automatic logic [7:0] ref_lane(logic [5:0] op, logic [7:0] a, logic [7:0] b);
        logic [7:0] r;
        case (op)
            6'h00: r = a + b;
            6'h01: r = a + b + 8'd1;
            6'h02: r = b - a - 8'd1;
            6'h03: r = b - a;
            6'h04: r = a - b - 8'd1;
            6'h05: r = a - b;
            6'h06: r = (~a) + (~b);
            6'h07: r = (~a) + (~b) + 8'd1;
            6'h28: r = a & b;
            6'h1E: r = a | b;
            6'h22: r = a ^ b;
            6'h20: r = ~(a ^ b);
            6'h18: r = ~(a & b);
            6'h2E: r = ~(a | b);
            6'h2A: r = (~a) & b;
            6'h2C: r = a & (~b);
            6'h1C: r = (~a) | b;
            6'h1A: r = a | (~b);
            6'h3E: r = a;
            6'h3C: r = ~a;
            6'h36: r = b;
            6'h32: r = ~b;
            6'h38: r = 8'h00;
            6'h30: r = 8'hFF;
            default: r = b;
        endcase
        return r;
    endfunction

    function automatic logic [23:0] ref_color(logic [5:0] op, logic [23:0] a, logic [23:0] b,
                                              logic [23:0] mask);
        logic [23:0] r;
        for (int c = 0; c < 3; c++) r[c*8 +: 8] = ref_lane(op, a[c*8 +: 8], b[c*8 +: 8]);
        return (r & mask) | (b & ~mask);
    endfunction

    function automatic logic ref_pass(logic [1:0] sel, logic off, logic [15:0] zn, logic [15:0] zo);
        logic p;
        case (sel)
            2'b00: p = zn >= zo;
            2'b01: p = zn > zo;
            2'b10: p = zn < zo;
            default: p = zn == zo;
        endcase
        return p | off;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [1:0] addr, logic [23:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (addr)
            2'd0: m_rop = data[5:0];
            2'd1: begin m_sel = data[1:0]; m_off = data[2]; m_pol = data[4:3]; end
            2'd2: m_mask = data;
            default: ;
        endcase
    endtask

    task automatic set_depth(logic [1:0] sel, logic off, logic [1:0] pol);
        write_cfg(2'd1, {19'd0, pol, off, sel});
    endtask

    // Presents one pixel, checks the outputs one edge later.
    task automatic send(string req, logic [23:0] a, logic [23:0] b, logic [15:0] zn, logic [15:0] zo);
        logic p, efb, ezb;
        @(negedge clk);
        pix_valid = 1'b1; pix_src = a; pix_dst = b; pix_znew = zn; pix_zold = zo;
        @(posedge clk);
        @(negedge clk);
        pix_valid = 1'b0;
        p = ref_pass(m_sel, m_off, zn, zo);
        case (m_pol)
            2'd0: begin efb = p;    ezb = p;    end
            2'd1: begin efb = p;    ezb = 1'b0; end
            2'd2: begin efb = 1'b1; ezb = 1'b1; end
            default: begin efb = 1'b1; ezb = 1'b0; end
        endcase
        check({req, " R2 valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " R2 depth"}, {16'd0, out_depth}, {16'd0, zn});
        check({req, " color"}, {8'd0, out_color}, {8'd0, ref_color(m_rop, a, b, m_mask)});
        check({req, " fb_we"}, {31'd0, fb_we}, {31'd0, efb});
        check({req, " zb_we"}, {31'd0, zb_we}, {31'd0, ezb});
    endtask

    localparam int N_CODES = 24;
    logic [5:0] codes [N_CODES] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07,
                                    6'h28, 6'h1E, 6'h22, 6'h20, 6'h18, 6'h2E, 6'h2A, 6'h2C,
                                    6'h1C, 6'h1A, 6'h3E, 6'h3C, 6'h36, 6'h32, 6'h38, 6'h30};

    initial begin
        int seed;
        seed = 32'h5EED1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: outputs low during reset.
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset fb_we", {31'd0, fb_we}, 32'd0);
        check("R1 reset zb_we", {31'd0, zb_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {30'd0, out_valid, fb_we | zb_we}, 32'd0);
        // R1: default configuration passes A, full mask, >= compare, policy 0.
        send("R1 default", 24'h123456, 24'hABCDEF, 16'd5, 16'd5);
        send("R1 default fail", 24'h123456, 24'hABCDEF, 16'd4, 16'd5);

        // R3: arithmetic family with wrap per channel.
        for (int k = 0; k < 8; k++) begin
            write_cfg(2'd0, {18'd0, codes[k]});
            send("R3 wrap", 24'hFF0180, 24'h02FF80, 16'd1, 16'd0);
            send("R3 zero", 24'h000000, 24'hFFFFFF, 16'd1, 16'd0);
        end
        // R4, R5: every logic and constant code.
        for (int k = 8; k < N_CODES; k++) begin
            write_cfg(2'd0, {18'd0, codes[k]});
            send(k < 18 ? "R4 logic" : "R5 const", 24'hF0CC3A, 24'hAA5A0F, 16'd1, 16'd0);
        end
        // R6: unlisted codes keep the destination.
        write_cfg(2'd0, 24'h000008);
        send("R6 unlisted 08", 24'h111111, 24'h9ABCDE, 16'd1, 16'd0);
        write_cfg(2'd0, 24'h00003F);
        send("R6 unlisted 3F", 24'h111111, 24'h9ABCDE, 16'd1, 16'd0);

        // R7: plane mask.
        write_cfg(2'd0, 24'h000038);
        write_cfg(2'd2, 24'h0F00F0);
        send("R7 mask", 24'h123456, 24'hFFFFFF, 16'd1, 16'd0);
        write_cfg(2'd2, 24'h000000);
        send("R7 mask none", 24'h123456, 24'h5A5A5A, 16'd1, 16'd0);
        write_cfg(2'd2, 24'hFFFFFF);

        // R8: every compare select at equal and adjacent depths.
        for (int s = 0; s < 4; s++) begin
            set_depth(s[1:0], 1'b0, 2'd0);
            send("R8 eq", 24'h1, 24'h2, 16'h8000, 16'h8000);
            send("R8 gt", 24'h1, 24'h2, 16'h8001, 16'h8000);
            send("R8 lt", 24'h1, 24'h2, 16'h7FFF, 16'h8000);
            send("R8 max", 24'h1, 24'h2, 16'hFFFF, 16'h0000);
        end
        // R9: compare off passes a failing test.
        set_depth(2'b11, 1'b1, 2'd0);
        send("R9 off pol0", 24'h1, 24'h2, 16'd1, 16'd9);
        set_depth(2'b11, 1'b1, 2'd1);
        send("R9 off pol1", 24'h1, 24'h2, 16'd1, 16'd9);
        // R10: every policy with pass and fail.
        for (int pl = 0; pl < 4; pl++) begin
            set_depth(2'b11, 1'b0, pl[1:0]);
            send("R10 pass", 24'h1, 24'h2, 16'd7, 16'd7);
            send("R10 fail", 24'h1, 24'h2, 16'd6, 16'd7);
        end

        // R11: write to address 3 changes nothing.
        set_depth(2'b00, 1'b0, 2'd0);
        write_cfg(2'd0, 24'h000022);
        write_cfg(2'd3, 24'hFFFFFF);
        send("R11 spare ignored", 24'h0F0F0F, 24'h00FF00, 16'd3, 16'd3);
        // R11: pixel in the same cycle as a write sees the old code.
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_data = 24'h000038;
        pix_valid = 1'b1; pix_src = 24'h0F0F0F; pix_dst = 24'h00FF00; pix_znew = 16'd3; pix_zold = 16'd3;
        @(negedge clk);
        cfg_we = 1'b0; pix_valid = 1'b0;
        check("R11 old config", {8'd0, out_color}, 32'h000FF00F);
        m_rop = 6'h38;
        send("R11 new config", 24'h0F0F0F, 24'h00FF00, 16'd3, 16'd3);

        // R12: idle cycle with defined data writes nothing.
        @(negedge clk);
        pix_valid = 1'b0; pix_src = 24'hFFFFFF; pix_znew = 16'hFFFF; pix_zold = 16'h0;
        set_depth(2'b00, 1'b0, 2'd2);
        @(negedge clk);
        check("R12 idle valid", {31'd0, out_valid}, 32'd0);
        check("R12 idle we", {30'd0, fb_we, zb_we}, 32'd0);

        // Random traffic.
        for (int it = 0; it < 1500; it++) begin
            if (it % 8 == 0) begin
                logic [5:0] op;
                op = ($urandom % 5 == 0) ? 6'($urandom) : codes[$urandom % N_CODES];
                write_cfg(2'd0, {18'd0, op});
                set_depth(2'($urandom), 1'($urandom), 2'($urandom));
                write_cfg(2'd2, ($urandom % 2 == 0) ? 24'hFFFFFF : 24'($urandom));
            end
            begin
                logic [15:0] zo, zn;
                zo = 16'($urandom);
                case ($urandom % 3)
                    0: zn = zo;
                    1: zn = zo + 16'd1;
                    default: zn = 16'($urandom);
                endcase
                send("R3-R10 random", 24'($urandom), 24'($urandom), zn, zo);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule